// File: doc/BRIEF.md
# Scan-Controlled Pulse and Port Gating Slice

This block is a slice of a scan gateway that fans one test access port out to six downstream scan ports. It contains a complete 1149.1 TAP state machine, a four-bit instruction register and three private data registers, each reached by its own opcode. Two of them are one-bit pulse registers. A scan through one of them strobes a pin low for a single TCK period. The pulse comes from the Update-DR state, so a test tool can fire it without leaving the gateway's test-logic state.

The first pulse register drives a board self-test pin. The second drives the test-reset lines of all six downstream ports together. Because the gateway's own reset is not used, its setup survives a downstream reset test. The third register is six bits wide and acts as a per-port gate for an auxiliary pass-through signal. Each port either forwards that signal or releases its output to high impedance, which is shown here by a separate enable bit.

Top module: `jpg_top`

## Requirements
- R1: While rst_ni is low, the TAP is held in Test-Logic-Reset, the gate register reads all zeros, selftest_no and every port_rst_no bit read 1, and tdo_en_o reads 0.
- R2: The TAP follows the standard 16-state diagram on rising TCK. Five rising edges with TMS high reach Test-Logic-Reset from any state. In Capture-IR the instruction shift register loads binary 0001, and it shifts out LSB first.
- R3: The opcodes are: 1111 bypass, 0010 self-test, 0011 port reset, 0100 gate. Any other opcode selects the one-bit bypass register, which captures 0 and delays TDI by one shift.
- R4: The self-test and port-reset bits are single-bit registers placed between TDI and TDO. Each is cleared to 0 in Capture-DR.
- R5: With the self-test opcode loaded, a DR scan that leaves the bit at 0 drives selftest_no low for exactly one TCK period. The pulse starts on the falling edge in Update-DR. The port reset lines do not move.
- R6: With the port-reset opcode loaded, the same scan drives all six port_rst_no bits low together for exactly one TCK period. selftest_no and the gate register are left unchanged.
- R7: If a 1 is shifted into a pulse bit before Update-DR, no pulse is produced.
- R8: Gate bit k (bits 2..0 for ports 1 to 3, bits 5..3 for ports 4 to 6) sets aux_en_o[k]. aux_o[k] equals aux_i when the bit is 1 and 0 when it is 0.
- R9: The gate register shifts LSB first. Its outputs change only on leaving Update-DR, so they hold their old value through Shift-DR and Exit1-DR.
- R10: In Capture-DR the gate shift register loads the gate register's current value, so a scan returns the previously loaded value.
- R11: Entering Test-Logic-Reset through TMS clears the gate register and selects bypass.
- R12: tdo_o and tdo_en_o change on falling TCK. tdo_en_o is 1 only in the cycles that follow Shift-DR or Shift-IR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock |
| rst_ni | input | 1 | Asynchronous active-low test reset |
| tms_i | input | 1 | Test mode select |
| tdi_i | input | 1 | Test data in |
| aux_i | input | 1 | Auxiliary signal to be passed through |
| tdo_o | output | 1 | Test data out, updated on falling TCK |
| tdo_en_o | output | 1 | TDO drive enable |
| selftest_no | output | 1 | Active-low self-test pulse |
| port_rst_no | output | 6 | Active-low reset pulse to each downstream port |
| aux_o | output | 6 | Per-port auxiliary output |
| aux_en_o | output | 6 | Per-port auxiliary drive enable (0 = high impedance) |

## Verification
The hardest case to reach from the ports is the one where a pulse must not disturb anything else. A downstream reset strobe has to leave a non-zero gate pattern in place, and shifting a 1 into a pulse bit has to suppress the strobe. The bench loads a distinctive gate pattern first and then runs the port-reset scan. It counts low cycles on every pulse pin at each rising edge and rereads the gate outputs afterwards. Gate hold-off during a scan is checked by sampling the enables at Exit1-DR, before the update edge. Capture of the current value is checked by comparing each scan's shifted-out word with the word loaded by the previous scan.

// File: rtl/jpg_pkg.sv
package jpg_pkg;
  localparam int IR_W = 4;

  typedef enum logic [3:0] {
    S_TLR, S_RTI, S_SEL_DR, S_CAP_DR, S_SH_DR, S_EX1_DR, S_PA_DR, S_EX2_DR,
    S_UPD_DR, S_SEL_IR, S_CAP_IR, S_SH_IR, S_EX1_IR, S_PA_IR, S_EX2_IR, S_UPD_IR
  } tap_state_e;

  localparam logic [IR_W-1:0] OP_BYPASS   = 4'b1111;
  localparam logic [IR_W-1:0] OP_SELFTEST = 4'b0010;
  localparam logic [IR_W-1:0] OP_PORTRST  = 4'b0011;
  localparam logic [IR_W-1:0] OP_GATE     = 4'b0100;
  localparam logic [IR_W-1:0] IR_CAPTURE  = 4'b0001;
endpackage

// File: rtl/jpg_tap_fsm.sv
module jpg_tap_fsm
  import jpg_pkg::*;
(
  input  logic       tck_i,
  input  logic       rst_ni,
  input  logic       tms_i,
  output tap_state_e state_o
);
  tap_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_TLR:    state_d = tms_i ? S_TLR    : S_RTI;
      S_RTI:    state_d = tms_i ? S_SEL_DR : S_RTI;
      S_SEL_DR: state_d = tms_i ? S_SEL_IR : S_CAP_DR;
      S_CAP_DR: state_d = tms_i ? S_EX1_DR : S_SH_DR;
      S_SH_DR:  state_d = tms_i ? S_EX1_DR : S_SH_DR;
      S_EX1_DR: state_d = tms_i ? S_UPD_DR : S_PA_DR;
      S_PA_DR:  state_d = tms_i ? S_EX2_DR : S_PA_DR;
      S_EX2_DR: state_d = tms_i ? S_UPD_DR : S_SH_DR;
      S_UPD_DR: state_d = tms_i ? S_SEL_DR : S_RTI;
      S_SEL_IR: state_d = tms_i ? S_TLR    : S_CAP_IR;
      S_CAP_IR: state_d = tms_i ? S_EX1_IR : S_SH_IR;
      S_SH_IR:  state_d = tms_i ? S_EX1_IR : S_SH_IR;
      S_EX1_IR: state_d = tms_i ? S_UPD_IR : S_PA_IR;
      S_PA_IR:  state_d = tms_i ? S_EX2_IR : S_PA_IR;
      S_EX2_IR: state_d = tms_i ? S_UPD_IR : S_SH_IR;
      S_UPD_IR: state_d = tms_i ? S_SEL_DR : S_RTI;
      default:  state_d = S_TLR;
    endcase
  end

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= S_TLR;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  AST_TLR_STICKY: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_q == S_TLR && tms_i) |=> (state_q == S_TLR)); // R2
  AST_UPD_LEAVES: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_q == S_UPD_DR) |=> (state_q != S_UPD_DR)); // R5
endmodule

// File: rtl/jpg_ir.sv
module jpg_ir
  import jpg_pkg::*;
(
  input  logic            tck_i,
  input  logic            rst_ni,
  input  tap_state_e      state_i,
  input  logic            tdi_i,
  output logic [IR_W-1:0] ir_o,
  output logic            so_o
);
  logic [IR_W-1:0] sr_q, ir_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q <= IR_CAPTURE;
      ir_q <= OP_BYPASS;
    end else begin
      case (state_i)
        S_CAP_IR: sr_q <= IR_CAPTURE;
        S_SH_IR:  sr_q <= {tdi_i, sr_q[IR_W-1:1]};
        S_UPD_IR: ir_q <= sr_q;
        S_TLR:    ir_q <= OP_BYPASS;
        default:  ;
      endcase
    end
  end

  assign ir_o = ir_q;
  assign so_o = sr_q[0];

  AST_IR_CAPTURE: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_i == S_CAP_IR) |=> (sr_q == IR_CAPTURE)); // R2
  AST_IR_TLR: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_i == S_TLR) |=> (ir_q == OP_BYPASS)); // R11
endmodule

// File: rtl/jpg_pulse_bit.sv
module jpg_pulse_bit (
  input  logic tck_i,
  input  logic rst_ni,
  input  logic sel_i,
  input  logic cap_i,
  input  logic shift_i,
  input  logic upd_i,
  input  logic tdi_i,
  output logic so_o,
  output logic pulse_no
);
  logic bit_q, pulse_nq;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)               bit_q <= 1'b0;
    else if (sel_i && cap_i)   bit_q <= 1'b0;
    else if (sel_i && shift_i) bit_q <= tdi_i;
  end

  // low from the falling edge in Update-DR to the next falling edge
  always_ff @(negedge tck_i or negedge rst_ni) begin
    if (!rst_ni) pulse_nq <= 1'b1;
    else         pulse_nq <= !(sel_i && upd_i && !bit_q);
  end

  assign so_o     = bit_q;
  assign pulse_no = pulse_nq;

  AST_PULSE_ONE_CYCLE: assert property (@(posedge tck_i) disable iff (!rst_ni)
    $fell(pulse_nq) |=> pulse_nq); // R5
  AST_CAPTURE_ZERO: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (sel_i && cap_i) |=> !bit_q); // R4
endmodule

// File: rtl/jpg_gate_reg.sv
module jpg_gate_reg #(
  parameter int W = 6
) (
  input  logic         tck_i,
  input  logic         rst_ni,
  input  logic         sel_i,
  input  logic         cap_i,
  input  logic         shift_i,
  input  logic         upd_i,
  input  logic         tlr_i,
  input  logic         tdi_i,
  output logic         so_o,
  output logic [W-1:0] gate_o
);
  logic [W-1:0] sr_q, gate_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)               sr_q <= '0;
    else if (sel_i && cap_i)   sr_q <= gate_q;
    else if (sel_i && shift_i) sr_q <= {tdi_i, sr_q[W-1:1]};
  end

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)             gate_q <= '0;
    else if (tlr_i)          gate_q <= '0;
    else if (sel_i && upd_i) gate_q <= sr_q;
  end

  assign so_o   = sr_q[0];
  assign gate_o = gate_q;

  AST_GATE_HOLD: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (!(sel_i && upd_i) && !tlr_i) |=> $stable(gate_q)); // R9
  AST_GATE_CAPTURE: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (sel_i && cap_i) |=> (sr_q == gate_q)); // R10
  AST_GATE_TLR: assert property (@(posedge tck_i) disable iff (!rst_ni)
    tlr_i |=> (gate_q == '0)); // R11
endmodule

// File: rtl/jpg_top.sv
module jpg_top
  import jpg_pkg::*;
#(
  parameter int NUM_PORTS = 6,
  parameter int GRP_SIZE  = 3
) (
  input  logic                 tck_i,
  input  logic                 rst_ni,
  input  logic                 tms_i,
  input  logic                 tdi_i,
  input  logic                 aux_i,
  output logic                 tdo_o,
  output logic                 tdo_en_o,
  output logic                 selftest_no,
  output logic [NUM_PORTS-1:0] port_rst_no,
  output logic [NUM_PORTS-1:0] aux_o,
  output logic [NUM_PORTS-1:0] aux_en_o
);
  localparam int NUM_GRPS = NUM_PORTS / GRP_SIZE;

  tap_state_e      state;
  logic [IR_W-1:0] ir;
  logic            ir_so, st_so, pr_so, gt_so, byp_q, dr_so, tdo_d;
  logic            cap_dr, sh_dr, upd_dr, tlr;
  logic            sel_st, sel_pr, sel_gt, sel_byp;
  logic            pr_pulse_n;
  logic [NUM_PORTS-1:0] gate;

  jpg_tap_fsm u_tap (
    .tck_i(tck_i), .rst_ni(rst_ni), .tms_i(tms_i), .state_o(state)
  );

  jpg_ir u_ir (
    .tck_i(tck_i), .rst_ni(rst_ni), .state_i(state), .tdi_i(tdi_i),
    .ir_o(ir), .so_o(ir_so)
  );

  assign cap_dr  = (state == S_CAP_DR);
  assign sh_dr   = (state == S_SH_DR);
  assign upd_dr  = (state == S_UPD_DR);
  assign tlr     = (state == S_TLR);
  assign sel_st  = (ir == OP_SELFTEST);
  assign sel_pr  = (ir == OP_PORTRST);
  assign sel_gt  = (ir == OP_GATE);
  assign sel_byp = !(sel_st || sel_pr || sel_gt);

  jpg_pulse_bit u_selftest (
    .tck_i(tck_i), .rst_ni(rst_ni), .sel_i(sel_st), .cap_i(cap_dr),
    .shift_i(sh_dr), .upd_i(upd_dr), .tdi_i(tdi_i),
    .so_o(st_so), .pulse_no(selftest_no)
  );

  jpg_pulse_bit u_portrst (
    .tck_i(tck_i), .rst_ni(rst_ni), .sel_i(sel_pr), .cap_i(cap_dr),
    .shift_i(sh_dr), .upd_i(upd_dr), .tdi_i(tdi_i),
    .so_o(pr_so), .pulse_no(pr_pulse_n)
  );

  jpg_gate_reg #(.W(NUM_PORTS)) u_gate (
    .tck_i(tck_i), .rst_ni(rst_ni), .sel_i(sel_gt), .cap_i(cap_dr),
    .shift_i(sh_dr), .upd_i(upd_dr), .tlr_i(tlr), .tdi_i(tdi_i),
    .so_o(gt_so), .gate_o(gate)
  );

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)                 byp_q <= 1'b0;
    else if (sel_byp && cap_dr)  byp_q <= 1'b0;
    else if (sel_byp && sh_dr)   byp_q <= tdi_i;
  end

  always_comb begin
    if (sel_st)      dr_so = st_so;
    else if (sel_pr) dr_so = pr_so;
    else if (sel_gt) dr_so = gt_so;
    else             dr_so = byp_q;
  end

  assign tdo_d = (state == S_SH_IR) ? ir_so : dr_so;

  always_ff @(negedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tdo_o    <= 1'b0;
      tdo_en_o <= 1'b0;
    end else begin
      tdo_o    <= tdo_d;
      tdo_en_o <= (state == S_SH_IR) || sh_dr;
    end
  end

  for (genvar g = 0; g < NUM_GRPS; g++) begin : g_grp
    for (genvar p = 0; p < GRP_SIZE; p++) begin : g_port
      localparam int K = g * GRP_SIZE + p;
      assign port_rst_no[K] = pr_pulse_n;
      assign aux_en_o[K]    = gate[K];
      assign aux_o[K]       = gate[K] & aux_i;
    end
  end

  AST_RST_TOGETHER: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (port_rst_no == '0) || (port_rst_no == '1)); // R6
  AST_PULSES_EXCLUSIVE: assert property (@(posedge tck_i) disable iff (!rst_ni)
    !(selftest_no == 1'b0 && port_rst_no != '1)); // R6
  AST_TDO_EN_SHIFT: assert property (@(negedge tck_i) disable iff (!rst_ni)
    !((state == S_SH_IR) || (state == S_SH_DR)) |=> !tdo_en_o); // R12
endmodule

// File: tb/tb_jpg_top.sv
`timescale 1ns/1ps
module tb_jpg_top;
  localparam int NP = 6;

  logic tck_i = 1'b0, rst_ni = 1'b0, tms_i = 1'b1, tdi_i = 1'b0, aux_i = 1'b0;
  logic tdo_o, tdo_en_o, selftest_no;
  logic [NP-1:0] port_rst_no, aux_o, aux_en_o;

  int checks = 0, fails = 0;
  int st_lo = 0, pr_lo = 0;
  logic [NP-1:0] pre_upd_en;
  logic en_seen;

  always #10 tck_i = ~tck_i;

  jpg_top dut (
    .tck_i(tck_i), .rst_ni(rst_ni), .tms_i(tms_i), .tdi_i(tdi_i), .aux_i(aux_i),
    .tdo_o(tdo_o), .tdo_en_o(tdo_en_o), .selftest_no(selftest_no),
    .port_rst_no(port_rst_no), .aux_o(aux_o), .aux_en_o(aux_en_o)
  );

  always @(posedge tck_i) begin
    if (selftest_no !== 1'b1) st_lo++;
    if (port_rst_no !== '1)   pr_lo++;
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic tick(input logic m, input logic d, output logic o);
    @(negedge tck_i); #2;
    o = tdo_o;
    tms_i = m; tdi_i = d;
    @(posedge tck_i); #1;
  endtask

  task automatic go_tlr_rti();
    logic o;
    for (int i = 0; i < 5; i++) tick(1'b1, 1'b0, o);
    tick(1'b0, 1'b0, o);
  endtask

  // from Run-Test/Idle, ends in Run-Test/Idle plus one idle cycle
  task automatic scan_ir(input logic [3:0] din, output logic [3:0] dout);
    logic o;
    tick(1, 0, o); tick(1, 0, o); tick(0, 0, o); tick(0, 0, o);
    for (int i = 0; i < 4; i++) begin
      tick(i == 3, din[i], o);
      dout[i] = o;
    end
    tick(1, 0, o); tick(0, 0, o); tick(0, 0, o);
  endtask

  task automatic scan_dr(input int n, input logic [7:0] din, output logic [7:0] dout);
    logic o;
    dout = '0;
    st_lo = 0; pr_lo = 0; en_seen = 1'b1;
    tick(1, 0, o); tick(0, 0, o); tick(0, 0, o);
    for (int i = 0; i < n; i++) begin
      tick(i == n - 1, din[i], o);
      dout[i] = o;
    end
    #3;
    en_seen = tdo_en_o;     // falling edge in Shift-DR has passed by the first bit
    pre_upd_en = aux_en_o;  // now in Exit1-DR
    tick(1, 0, o); tick(0, 0, o); tick(0, 0, o); tick(0, 0, o);
  endtask

  // {aux_i, gate}
  localparam logic [NP:0] VEC [8] = '{
    7'b1_000001, 7'b1_000010, 7'b0_000100, 7'b1_111000,
    7'b1_101010, 7'b0_010101, 7'b1_111111, 7'b1_000000
  };

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog: got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [3:0] iro;
    logic [7:0] dro;
    logic [NP-1:0] prev;
    repeat (3) @(posedge tck_i);
    #3;
    chk("R1 reset aux_en", {26'd0, aux_en_o}, 32'd0);
    chk("R1 reset selftest", {31'd0, selftest_no}, 32'd1);
    chk("R1 reset port_rst", {26'd0, port_rst_no}, 32'h3f);
    chk("R1 reset tdo_en", {31'd0, tdo_en_o}, 32'd0);
    rst_ni = 1'b1;
    go_tlr_rti();
    chk("R12 tdo_en idle", {31'd0, tdo_en_o}, 32'd0);

    // R2 capture 0001, R8/R9/R10 via vector table
    scan_ir(4'b0100, iro);
    chk("R2 IR capture", {28'd0, iro}, 32'd1);
    prev = '0;
    for (int v = 0; v < 8; v++) begin
      logic [NP-1:0] g;
      g = VEC[v][NP-1:0];
      aux_i = VEC[v][NP];
      scan_dr(NP, {2'b00, g}, dro);
      chk("R10 capture current", {24'd0, dro}, {26'd0, prev});
      chk("R9 hold until update", {26'd0, pre_upd_en}, {26'd0, prev});
      chk("R12 tdo_en in shift", {31'd0, en_seen}, 32'd1);
      chk("R8 aux_en map", {26'd0, aux_en_o}, {26'd0, g});
      chk("R8 aux_o gated", {26'd0, aux_o}, {26'd0, g & {NP{aux_i}}});
      prev = g;
    end

    // R5 self-test pulse; R4 capture zero
    scan_dr(NP, 8'b0010_1101, dro);
    aux_i = 1'b1;
    scan_ir(4'b0010, iro);
    scan_dr(1, 8'h01, dro);
    chk("R4 selftest bit captures 0", {24'd0, dro}, 32'd0);
    chk("R7 shifted 1 no pulse", st_lo, 0);
    scan_dr(1, 8'h00, dro);
    chk("R5 selftest one cycle", st_lo, 1);
    chk("R5 port resets quiet", pr_lo, 0);
    scan_dr(2, 8'b11, dro);
    chk("R4 single bit path", {24'd0, dro}, 32'b10);

    // R6 port reset pulse, gate preserved
    scan_ir(4'b0011, iro);
    scan_dr(1, 8'h00, dro);
    chk("R4 portrst captures 0", {24'd0, dro}, 32'd0);
    chk("R6 port reset one cycle", pr_lo, 1);
    chk("R6 selftest quiet", st_lo, 0);
    chk("R6 gate preserved", {26'd0, aux_en_o}, 32'h2d);
    scan_dr(1, 8'h01, dro);
    chk("R7 portrst suppressed", pr_lo, 0);

    // R3 unused opcode selects bypass
    scan_ir(4'b1010, iro);
    scan_dr(8, 8'b1011_0110, dro);
    chk("R3 bypass delay", {24'd0, dro}, {24'd0, 8'b0110_1100});
    chk("R3 gate untouched", {26'd0, aux_en_o}, 32'h2d);

    // R11 TMS reset clears gate, selects bypass
    go_tlr_rti();
    chk("R11 gate cleared", {26'd0, aux_en_o}, 32'd0);
    scan_dr(2, 8'b01, dro);
    chk("R11 bypass after TLR", {24'd0, dro}, 32'b10);

    // R1 async reset mid-scan
    scan_ir(4'b0100, iro);
    scan_dr(NP, 8'h3f, dro);
    chk("R8 all enabled", {26'd0, aux_en_o}, 32'h3f);
    @(negedge tck_i); #2 rst_ni = 1'b0;
    #5;
    chk("R1 async gate clear", {26'd0, aux_en_o}, 32'd0);
    chk("R1 async pulses high", {25'd0, selftest_no, port_rst_no}, 32'h7f);
    @(posedge tck_i); #3 rst_ni = 1'b1;
    go_tlr_rti();
    scan_dr(2, 8'b01, dro);
    chk("R1 bypass after reset", {24'd0, dro}, 32'b10);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule